// File: doc/BRIEF.md
# Synchronous Character-Hunt Receiver

This block receives a serial bit stream whose bits are already sampled at the line rate (one strobe per bit). It finds character alignment on its own and then delivers whole characters to a holding register. When it is enabled, it searches bit by bit for a programmable sync character. In double-sync operation a second sync character must follow directly before alignment is accepted. After that, it groups every following 5 to 8 data bits (plus an optional parity bit) into a character. Each character is checked, optionally discarded when it is a sync or escape filler, and otherwise loaded into the holding register with a ready flag.

As an alternative to the internal search, an external pulse can force alignment. The first bit strobed after the pulse's rising edge becomes the first bit of a character. The host side sees registered data, a data-ready flag, a sync-detected flag, a parity error flag and an overrun flag. Two one-cycle strobes clear the flags: one for reading status and one for reading data.

Top module: `sync_hunt_rx`

## Requirements
- R1: Raising `rx_en` starts the search for alignment. While `rx_en` is low, the receiver is idle and `rx_rdy` is forced to 0 from the next cycle.
- R2: While searching, on every bit strobe the most recent frame-length bits are compared with the first sync character. Bits arrive least significant bit first. The frame is the low `5+len_sel` bits of `syn1`, followed by its parity bit when parity is enabled (`len_sel` 0..3 selects 5..8 data bits).
- R3: In single-sync mode (`dbl_syn`=0), a match ends the search, sets `syn_det` and starts character assembly with the next bit.
- R4: In double-sync mode, the character that immediately follows the first sync character must equal `syn2`; otherwise the search resumes. The sequence syn1, syn1, syn2 therefore does not align.
- R5: The sync characters that establish alignment never reach the holding register, and `rx_rdy` stays 0 after them.
- R6: Once aligned, every assembled character not discarded by R7 is loaded into `rx_data` and sets `rx_rdy` in the following cycle. The first received bit goes to `rx_data[0]`, and the bits above the character length read as 0.
- R7: With `strip_en`=1, aligned characters equal to `syn1`, to `dle`, or (in double-sync mode) to `syn2` are discarded. With `strip_en`=0, they are loaded like any other character.
- R8: While aligned with the internal search active, a new sync sequence sets `syn_det` again. In single-sync mode this is a `syn1` character; in double-sync mode it is `syn1` directly followed by `syn2`.
- R9: With `par_en`=1, each loaded character updates `par_err`. Under even parity (`par_odd`=0) the data bits plus the parity bit must contain an even number of ones; under odd parity they must contain an odd number.
- R10: Each load sets `overrun` to the value `rx_rdy` had just before it, and the newer character replaces the older one.
- R11: With `jam_en`=1, the internal search is disabled. A rising edge on `xsync` makes the next bit strobe the first bit of a character and sets `syn_det`.
- R12: `stat_rd` clears `syn_det` and `data_rd` clears `rx_rdy`. A set condition in the same cycle takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receiver enable |
| bit_stb | input | 1 | One-cycle strobe marking a valid sampled bit |
| rx_bit | input | 1 | Sampled serial bit |
| len_sel | input | 2 | Data bits per character minus 5 |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1 = odd parity, 0 = even |
| dbl_syn | input | 1 | Double-sync mode |
| strip_en | input | 1 | Discard sync and escape characters |
| jam_en | input | 1 | External alignment mode |
| xsync | input | 1 | External alignment pulse |
| syn1 | input | 8 | First sync character |
| syn2 | input | 8 | Second sync character |
| dle | input | 8 | Escape character |
| stat_rd | input | 1 | Status read strobe |
| data_rd | input | 1 | Data read strobe |
| rx_data | output | 8 | Holding register |
| rx_rdy | output | 1 | Character ready |
| syn_det | output | 1 | Sync detected |
| par_err | output | 1 | Parity error of last load |
| overrun | output | 1 | Last load overwrote an unread character |

## Verification
On every cycle, the assertions check the following:
- disabling clears readiness;
- loads happen only from the aligned state;
- unused high data bits are zero;
- overrun follows a load onto an unread character;
- the read strobes clear their flags;
- the search cannot leave its state under external alignment without a pulse.

Only the bench scenarios can show the bit-level behaviour:
- the rejection of syn1, syn1, syn2;
- alignment at the exact bit;
- stripping of filler characters;
- parity polarity;
- jam alignment starting at the next strobe.

The bench shows these by comparing against an independent bit-accurate model under random framing, lengths and parity.

// File: rtl/srx_pkg.sv
package srx_pkg;
  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_HUNT  = 2'd1,
    RX_WAIT2 = 2'd2,
    RX_SYNC  = 2'd3
  } rx_state_t;
endpackage

// File: rtl/srx_shifter.sv
module srx_shifter #(
  parameter int SW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          stb,
  input  logic          din,
  output logic [SW-1:0] nxt
);
  logic [SW-1:0] sr_q;

  // newest bit enters at the top; the oldest falls off the bottom
  assign nxt = {din, sr_q[SW-1:1]};

  always_ff @(posedge clk) begin
    if (rst || clr) sr_q <= '0;
    else if (stb)   sr_q <= nxt;
  end
endmodule

// File: rtl/srx_frame_eval.sv
module srx_frame_eval #(
  parameter int DATA_W  = 8,
  parameter int LEN_W   = 2,
  parameter int MIN_LEN = 5
) (
  input  logic [DATA_W:0]   win,
  input  logic [LEN_W-1:0]  len_sel,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic [DATA_W-1:0] syn1,
  input  logic [DATA_W-1:0] syn2,
  input  logic [DATA_W-1:0] dle,
  output logic [DATA_W-1:0] data_o,
  output logic              par_bad,
  output logic [2:0]        hits,
  output logic [$clog2(DATA_W+2)-1:0] last_idx
);
  localparam int SW = DATA_W + 1;
  localparam int CW = $clog2(DATA_W + 2);

  logic [CW-1:0]     dlen, flen;
  logic [SW-1:0]     aligned;
  logic [DATA_W-1:0] mask;
  logic              pbit;
  logic [DATA_W-1:0] refs [3];

  function automatic logic par_of(input logic [DATA_W-1:0] x,
                                  input logic [DATA_W-1:0] m,
                                  input logic odd);
    return (^(x & m)) ^ odd;
  endfunction

  always_comb begin
    dlen     = CW'(MIN_LEN) + CW'(len_sel);
    flen     = dlen + CW'(par_en);
    last_idx = flen - CW'(1);
    aligned  = win >> (CW'(SW) - flen);
    for (int i = 0; i < DATA_W; i++) mask[i] = (CW'(i) < dlen);
    data_o   = aligned[DATA_W-1:0] & mask;
    pbit     = aligned[dlen];
    par_bad  = par_en && (pbit != par_of(data_o, mask, par_odd));
  end

  assign refs[0] = syn1;
  assign refs[1] = syn2;
  assign refs[2] = dle;

  for (genvar g = 0; g < 3; g++) begin : g_cmp
    assign hits[g] = (data_o == (refs[g] & mask)) &&
                     (!par_en || (pbit == par_of(refs[g], mask, par_odd)));
  end
endmodule

// File: rtl/srx_ctrl.sv
module srx_ctrl
  import srx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CW     = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_en,
  input  logic              bit_stb,
  input  logic              dbl_syn,
  input  logic              strip_en,
  input  logic              jam_en,
  input  logic              xsync,
  input  logic              stat_rd,
  input  logic              data_rd,
  input  logic [CW-1:0]     last_idx,
  input  logic [DATA_W-1:0] data_in,
  input  logic              par_bad,
  input  logic              hit1,
  input  logic              hit2,
  input  logic              hitd,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_rdy,
  output logic              syn_det,
  output logic              par_err,
  output logic              overrun,
  output logic              xfer
);
  rx_state_t     state;
  logic [CW-1:0] cnt;
  logic          prev1, pend, xsync_q;
  logic          stb_on, done, jam_take, hunt_hit, w2_done, s_done;
  logic          seq_hit, strip, syn_set, xs_rise;

  always_comb begin
    xs_rise  = xsync && !xsync_q;
    done     = (cnt == last_idx);
    stb_on   = rx_en && bit_stb && (state != RX_IDLE);
    jam_take = stb_on && pend;
    hunt_hit = stb_on && !pend && state == RX_HUNT && !jam_en && hit1;
    w2_done  = stb_on && !pend && state == RX_WAIT2 && done;
    s_done   = stb_on && !pend && state == RX_SYNC && done;
    seq_hit  = s_done && !jam_en && (dbl_syn ? (prev1 && hit2) : hit1);
    strip    = strip_en && (hit1 || (dbl_syn && hit2) || hitd);
    xfer     = s_done && !strip;
    syn_set  = jam_take || (hunt_hit && !dbl_syn) || (w2_done && hit2) || seq_hit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= RX_IDLE;
      cnt     <= '0;
      prev1   <= 1'b0;
      pend    <= 1'b0;
      xsync_q <= 1'b0;
      rx_data <= '0;
      rx_rdy  <= 1'b0;
      syn_det <= 1'b0;
      par_err <= 1'b0;
      overrun <= 1'b0;
    end else begin
      xsync_q <= xsync;
      if (stat_rd) syn_det <= 1'b0;
      if (data_rd) rx_rdy  <= 1'b0;
      if (syn_set) syn_det <= 1'b1;
      if (!rx_en) begin
        state  <= RX_IDLE;
        cnt    <= '0;
        pend   <= 1'b0;
        prev1  <= 1'b0;
        rx_rdy <= 1'b0;
      end else begin
        if (state == RX_IDLE) state <= RX_HUNT;
        if (jam_take) begin
          pend  <= 1'b0;
          state <= RX_SYNC;
          cnt   <= CW'(1);
          prev1 <= 1'b0;
        end else if (stb_on) begin
          case (state)
            RX_HUNT: begin
              if (hunt_hit) begin
                state <= dbl_syn ? RX_WAIT2 : RX_SYNC;
                cnt   <= '0;
                prev1 <= 1'b0;
              end
            end
            RX_WAIT2: begin
              if (done) begin
                state <= hit2 ? RX_SYNC : RX_HUNT;
                cnt   <= '0;
                prev1 <= 1'b0;
              end else cnt <= cnt + CW'(1);
            end
            RX_SYNC: begin
              if (done) begin
                cnt   <= '0;
                prev1 <= hit1;
                if (xfer) begin
                  rx_data <= data_in;
                  overrun <= rx_rdy;
                  par_err <= par_bad;
                  rx_rdy  <= 1'b1;
                end
              end else cnt <= cnt + CW'(1);
            end
            default: ;
          endcase
        end
        if (jam_en && xs_rise) pend <= 1'b1;
      end
    end
  end

  // R1: a low enable leaves the receiver idle and not ready
  assert_off_clears_R1: assert property (@(posedge clk) disable iff (rst)
    !rx_en |=> (!rx_rdy && state == RX_IDLE));
  // R5: a character becomes ready only from the aligned state
  assert_load_from_sync_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_rdy) |-> $past(state) == RX_SYNC);
  // R10: loading over an unread character flags overrun
  assert_overrun_R10: assert property (@(posedge clk) disable iff (rst)
    (xfer && rx_rdy) |=> overrun);
  // R12: read strobes clear their flags when nothing sets them
  assert_data_read_R12: assert property (@(posedge clk) disable iff (rst)
    (data_rd && !xfer) |=> !rx_rdy);
  assert_stat_read_R12: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && !syn_set) |=> !syn_det);
  // R11: under external alignment the search holds without a pulse
  assert_jam_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (rx_en && jam_en && state == RX_HUNT && !pend && !xs_rise)
      |=> (state == RX_HUNT || state == RX_IDLE));
endmodule

// File: rtl/sync_hunt_rx.sv
module sync_hunt_rx #(
  parameter int DATA_W  = 8,
  parameter int LEN_W   = 2,
  parameter int MIN_LEN = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_en,
  input  logic              bit_stb,
  input  logic              rx_bit,
  input  logic [LEN_W-1:0]  len_sel,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              dbl_syn,
  input  logic              strip_en,
  input  logic              jam_en,
  input  logic              xsync,
  input  logic [DATA_W-1:0] syn1,
  input  logic [DATA_W-1:0] syn2,
  input  logic [DATA_W-1:0] dle,
  input  logic              stat_rd,
  input  logic              data_rd,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_rdy,
  output logic              syn_det,
  output logic              par_err,
  output logic              overrun
);
  localparam int SW = DATA_W + 1;
  localparam int CW = $clog2(DATA_W + 2);

  logic [SW-1:0]     win;
  logic [DATA_W-1:0] data_w;
  logic              par_bad, xfer;
  logic [2:0]        hits;
  logic [CW-1:0]     last_idx;

  srx_shifter #(.SW(SW)) u_shift (
    .clk(clk), .rst(rst), .clr(!rx_en), .stb(bit_stb), .din(rx_bit), .nxt(win)
  );

  srx_frame_eval #(.DATA_W(DATA_W), .LEN_W(LEN_W), .MIN_LEN(MIN_LEN)) u_eval (
    .win(win), .len_sel(len_sel), .par_en(par_en), .par_odd(par_odd),
    .syn1(syn1), .syn2(syn2), .dle(dle),
    .data_o(data_w), .par_bad(par_bad), .hits(hits), .last_idx(last_idx)
  );

  srx_ctrl #(.DATA_W(DATA_W), .CW(CW)) u_ctrl (
    .clk(clk), .rst(rst), .rx_en(rx_en), .bit_stb(bit_stb),
    .dbl_syn(dbl_syn), .strip_en(strip_en), .jam_en(jam_en), .xsync(xsync),
    .stat_rd(stat_rd), .data_rd(data_rd), .last_idx(last_idx),
    .data_in(data_w), .par_bad(par_bad),
    .hit1(hits[0]), .hit2(hits[1]), .hitd(hits[2]),
    .rx_data(rx_data), .rx_rdy(rx_rdy), .syn_det(syn_det),
    .par_err(par_err), .overrun(overrun), .xfer(xfer)
  );

  // R6: bits above the character length are zero on every fresh load
  assert_zero_high_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_rdy) |-> ((rx_data >> (MIN_LEN + int'($past(len_sel)))) == '0));
endmodule

// File: tb/sync_hunt_rx_tb_top.sv
module sync_hunt_rx_tb_top;
  logic clk = 0, rst = 1;
  logic rx_en = 0, bit_stb = 0, rx_bit = 0;
  logic [1:0] len_sel = 0;
  logic par_en = 0, par_odd = 0, dbl_syn = 0, strip_en = 0, jam_en = 0, xsync = 0;
  logic [7:0] syn1 = 8'h16, syn2 = 8'h19, dle = 8'h10;
  logic stat_rd = 0, data_rd = 0;
  logic [7:0] rx_data;
  logic rx_rdy, syn_det, par_err, overrun;

  int checks = 0, fails = 0;
  bit finished = 0;

  // bench model state: 0 idle, 1 hunt, 2 wait second, 3 aligned
  int m_state = 0, m_cnt = 0;
  logic [8:0] m_sr = 0;
  logic m_prev = 0, m_pend = 0, m_xq = 0;
  logic [7:0] m_data = 0;
  logic m_rdy = 0, m_syn = 0, m_pe = 0, m_ov = 0;

  always #5 clk = ~clk;

  sync_hunt_rx dut_i (
    .clk(clk), .rst(rst), .rx_en(rx_en), .bit_stb(bit_stb), .rx_bit(rx_bit),
    .len_sel(len_sel), .par_en(par_en), .par_odd(par_odd), .dbl_syn(dbl_syn),
    .strip_en(strip_en), .jam_en(jam_en), .xsync(xsync),
    .syn1(syn1), .syn2(syn2), .dle(dle), .stat_rd(stat_rd), .data_rd(data_rd),
    .rx_data(rx_data), .rx_rdy(rx_rdy), .syn_det(syn_det),
    .par_err(par_err), .overrun(overrun)
  );

  function automatic int dbits();
    return 5 + int'(len_sel);
  endfunction

  function automatic logic exp_par(input logic [7:0] x);
    int ones = 0;
    for (int j = 0; j < dbits(); j++) ones += int'(x[j]);
    return logic'(ones % 2) ^ par_odd;
  endfunction

  function automatic logic [7:0] lowm(input logic [7:0] x);
    logic [7:0] r = 0;
    for (int j = 0; j < dbits(); j++) r[j] = x[j];
    return r;
  endfunction

  task automatic model_clock(input logic stb, input logic b,
                             input logic srd, input logic drd);
    logic [8:0] nx;
    logic [7:0] d;
    logic pb, h1, h2, hd, pbad, son, dn, jt, hh, w2, sd, sq, stp, xf, ss, xr, ordy;
    int f, st;
    nx = {b, m_sr[8:1]};
    f  = dbits() + int'(par_en);
    d  = 0; pb = 0;
    for (int j = 0; j < f; j++) begin
      if (j < dbits()) d[j] = nx[9 - f + j];
      else pb = nx[9 - f + j];
    end
    pbad = par_en && (pb != exp_par(d));
    h1 = (d == lowm(syn1)) && (!par_en || pb == exp_par(syn1));
    h2 = (d == lowm(syn2)) && (!par_en || pb == exp_par(syn2));
    hd = (d == lowm(dle))  && (!par_en || pb == exp_par(dle));
    son = rx_en && stb && m_state != 0;
    dn  = (m_cnt == f - 1);
    jt  = son && m_pend;
    hh  = son && !m_pend && m_state == 1 && !jam_en && h1;
    w2  = son && !m_pend && m_state == 2 && dn;
    sd  = son && !m_pend && m_state == 3 && dn;
    sq  = sd && !jam_en && (dbl_syn ? (m_prev && h2) : h1);
    stp = strip_en && (h1 || (dbl_syn && h2) || hd);
    xf  = sd && !stp;
    ss  = jt || (hh && !dbl_syn) || (w2 && h2) || sq;
    xr  = xsync && !m_xq;
    ordy = m_rdy;
    m_xq = xsync;
    if (srd) m_syn = 0;
    if (drd) m_rdy = 0;
    if (ss) m_syn = 1;
    if (!rx_en) begin
      m_state = 0; m_cnt = 0; m_pend = 0; m_prev = 0; m_rdy = 0;
    end else begin
      st = m_state;
      if (st == 0) m_state = 1;
      if (jt) begin
        m_pend = 0; m_state = 3; m_cnt = 1; m_prev = 0;
      end else if (son) begin
        if (st == 1 && hh) begin
          m_state = dbl_syn ? 2 : 3; m_cnt = 0; m_prev = 0;
        end else if (st == 2) begin
          if (dn) begin m_state = h2 ? 3 : 1; m_cnt = 0; m_prev = 0; end
          else m_cnt++;
        end else if (st == 3) begin
          if (dn) begin
            m_cnt = 0; m_prev = h1;
            if (xf) begin m_data = d; m_ov = ordy; m_pe = pbad; m_rdy = 1; end
          end else m_cnt++;
        end
      end
      if (jam_en && xr) m_pend = 1;
    end
    if (!rx_en) m_sr = 0;
    else if (stb) m_sr = nx;
  endtask

  task automatic step(input logic stb, input logic b, input logic srd, input logic drd);
    bit_stb = stb; rx_bit = b; stat_rd = srd; data_rd = drd;
    model_clock(stb, b, srd, drd);
    @(negedge clk);
    bit_stb = 0; stat_rd = 0; data_rd = 0;
  endtask

  task automatic send_bit(input logic b);
    step(1, b, 0, 0);
    step(0, 0, 0, 0);
  endtask

  task automatic send_frame(input logic [7:0] c, input logic bad);
    for (int j = 0; j < dbits(); j++) send_bit(c[j]);
    if (par_en) send_bit(exp_par(c) ^ bad);
  endtask

  task automatic chk(input string tag, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic cmp(input string tag);
    chk(tag, "rx_data", rx_data, m_data);
    chk(tag, "rx_rdy", {7'd0, rx_rdy}, {7'd0, m_rdy});
    chk(tag, "syn_det", {7'd0, syn_det}, {7'd0, m_syn});
    chk(tag, "par_err", {7'd0, par_err}, {7'd0, m_pe});
    chk(tag, "overrun", {7'd0, overrun}, {7'd0, m_ov});
  endtask

  task automatic start(input logic [1:0] l, input logic pe, input logic po,
                       input logic db, input logic st, input logic jm);
    rx_en = 0; step(0, 0, 0, 0);
    len_sel = l; par_en = pe; par_odd = po; dbl_syn = db; strip_en = st; jam_en = jm;
    step(0, 0, 1, 1);
    rx_en = 1; step(0, 0, 0, 0); step(0, 0, 0, 0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // reset state
    chk("R1", "reset rx_rdy", {7'd0, rx_rdy}, 8'd0);
    chk("R1", "reset syn_det", {7'd0, syn_det}, 8'd0);
    chk("R6", "reset rx_data", rx_data, 8'd0);

    // R2 R3 R5 R6: single sync, 8 bits, no parity
    start(2'd3, 0, 0, 0, 0, 0);
    send_bit(1); send_bit(1); send_bit(1);
    send_frame(8'h16, 0);
    chk("R3", "syn_det after syn1", {7'd0, syn_det}, 8'd1);
    chk("R5", "rx_rdy after sync", {7'd0, rx_rdy}, 8'd0);
    cmp("R2");
    send_frame(8'hA5, 0);
    chk("R6", "rx_rdy", {7'd0, rx_rdy}, 8'd1);
    chk("R6", "rx_data", rx_data, 8'hA5);
    step(0, 0, 1, 0);
    chk("R12", "syn_det cleared", {7'd0, syn_det}, 8'd0);
    // R10: overrun on two unread characters
    send_frame(8'h3C, 0);
    chk("R10", "overrun", {7'd0, overrun}, 8'd1);
    chk("R10", "newer data", rx_data, 8'h3C);
    step(0, 0, 0, 1);
    chk("R12", "rx_rdy cleared", {7'd0, rx_rdy}, 8'd0);
    send_frame(8'h0F, 0);
    chk("R10", "no overrun", {7'd0, overrun}, 8'd0);
    // R8: syn1 while aligned sets syn_det again
    send_frame(8'h16, 0);
    chk("R8", "syn_det resync", {7'd0, syn_det}, 8'd1);
    cmp("R7");
    // R1: disable clears ready
    rx_en = 0; step(0, 0, 0, 0);
    chk("R1", "rx_rdy off", {7'd0, rx_rdy}, 8'd0);

    // R4: double sync
    start(2'd3, 0, 0, 1, 0, 0);
    send_bit(1); send_bit(1); send_bit(1);
    send_frame(8'h16, 0); send_frame(8'h16, 0); send_frame(8'h19, 0);
    chk("R4", "syn1 syn1 syn2 rejected", {7'd0, syn_det}, 8'd0);
    send_frame(8'h16, 0); send_frame(8'h19, 0);
    chk("R4", "syn1 syn2 aligns", {7'd0, syn_det}, 8'd1);
    chk("R5", "no load of sync pair", {7'd0, rx_rdy}, 8'd0);
    step(0, 0, 1, 0);
    send_frame(8'h16, 0); send_frame(8'h19, 0);
    chk("R8", "pair in sync", {7'd0, syn_det}, 8'd1);
    chk("R7", "no strip loads syn2", rx_data, 8'h19);
    cmp("R4");

    // R7: stripping
    start(2'd3, 0, 0, 0, 1, 0);
    send_bit(1); send_bit(1); send_bit(1);
    send_frame(8'h16, 0);
    send_frame(8'h16, 0); send_frame(8'h10, 0);
    chk("R7", "syn1 and dle stripped", {7'd0, rx_rdy}, 8'd0);
    send_frame(8'h3C, 0);
    chk("R7", "data kept", rx_data, 8'h3C);

    // R9: 5 bits even parity
    start(2'd0, 1, 0, 0, 0, 0);
    send_frame(8'h16, 0);
    chk("R9", "sync with parity", {7'd0, syn_det}, 8'd1);
    send_frame(8'h0B, 1);
    chk("R9", "bad parity flagged", {7'd0, par_err}, 8'd1);
    chk("R6", "5 bit data", rx_data, 8'h0B);
    send_frame(8'h0B, 0);
    chk("R9", "good parity", {7'd0, par_err}, 8'd0);
    cmp("R9");

    // R11: external alignment
    start(2'd3, 0, 0, 0, 0, 1);
    send_frame(8'h16, 0);
    chk("R11", "internal search off", {7'd0, syn_det}, 8'd0);
    xsync = 1; step(0, 0, 0, 0);
    send_frame(8'h5A, 0);
    chk("R11", "jam syn_det", {7'd0, syn_det}, 8'd1);
    chk("R11", "jam data", rx_data, 8'h5A);
    xsync = 0; step(0, 0, 0, 0);
    cmp("R11");

    // random framings against the model
    for (int r = 0; r < 8; r++) begin
      syn1 = 8'($urandom); syn2 = 8'($urandom); dle = 8'($urandom);
      start(2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 0);
      repeat (3 + $urandom % 6) send_bit(1'($urandom));
      send_frame(syn1, 0);
      if (dbl_syn) send_frame(syn2, 0);
      cmp("R3");
      for (int k = 0; k < 25; k++) begin
        logic [7:0] c;
        int p;
        p = $urandom % 8;
        c = (p == 0) ? syn1 : (p == 1) ? syn2 : (p == 2) ? dle : 8'($urandom);
        send_frame(c, ($urandom % 5) == 0);
        cmp("R6");
        if ($urandom % 3 == 0) begin
          step(0, 0, 1'($urandom), 1'($urandom));
          cmp("R12");
        end
      end
    end
    finish_run();
  end
endmodule